// File: doc/BRIEF.md
# Watchdog Frequency Recovery Controller

This block guards software-driven changes to a clock generator's output frequency. A watchdog counter advances on a reference tick while armed. When software stops restarting it, the counter expires. The block then pulses a system reset and moves the frequency selection to a recovery setting. It keeps that setting locked until software clears the watchdog enable.

In normal operation a frequency-write strobe loads the active selection. The override bit chooses between the power-up strap code and a software code. On expiry, a source bit chooses the recovery setting: either the strap code or an explicit N/M divider pair. The intended sequence is to arm the watchdog first and then change the frequency, so that a hang after the change is undone without outside help.

Top module: `wdt_freq_recovery`

## Requirements
- R1: With the enable set and ticks on every cycle, recovery begins exactly `timeout` ticks after the enable write, and not one tick earlier.
- R2: A kick pulse or an enable-register write restarts the count from zero, so regular kicks prevent expiry.
- R3: The watchdog advances only on cycles where `tick_i` is high; cycles without a tick do not move it toward expiry.
- R4: Every expiry produces one `sys_rst_o` pulse that lasts exactly 8 reference ticks, starting the clock after the expiry.
- R5: An expiry with `rcv_src_i` = 0 selects the latched strap code on `freq_code_o` and drives `use_nm_o` = 0.
- R6: An expiry with `rcv_src_i` = 1 drives `use_nm_o` = 1, with `n_o` and `m_o` equal to `rcv_n_i` and `rcv_m_i`.
- R7: `recovery_o` rises at expiry. While it is high, frequency writes leave the outputs unchanged and raise no reset, and the watchdog does not expire again.
- R8: Dropping `wd_en_i` clears `recovery_o` on the next clock and stops the count. No expiry happens while the enable is low, and frequency writes work again afterwards.
- R9: In normal mode a frequency write loads the strap code when `ovr_i` = 0 and `sw_code_i` when `ovr_i` = 1, with `use_nm_o` = 0. It takes effect on the next clock.
- R10: A normal frequency write that changes the selection starts an 8-tick reset pulse. A write that leaves the selection unchanged starts no pulse.
- R11: After reset, `freq_code_o` holds the strap code and `use_nm_o`, `sys_rst_o` and `recovery_o` are 0.
- R12: The strap code is captured once, on the first clock after reset. Later changes on `strap_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Reference tick, one-cycle pulse |
| wd_en_i | input | 1 | Watchdog enable field |
| en_wr_i | input | 1 | Strobe: enable register written |
| kick_i | input | 1 | Watchdog restart pulse |
| timeout_i | input | CNT_W | Timeout length in ticks |
| rcv_src_i | input | 1 | Recovery source: 0 strap code, 1 N/M pair |
| rcv_n_i | input | 8 | Recovery N value |
| rcv_m_i | input | 7 | Recovery M value |
| sw_code_i | input | 5 | Software frequency code |
| ovr_i | input | 1 | Override: 1 selects software code |
| strap_i | input | 5 | Strap code sampled after reset |
| freq_wr_i | input | 1 | Strobe: frequency register written |
| freq_code_o | output | 5 | Active frequency code |
| use_nm_o | output | 1 | Active selection is the N/M pair |
| n_o | output | 8 | Active N value |
| m_o | output | 7 | Active M value |
| sys_rst_o | output | 1 | System reset pulse |
| recovery_o | output | 1 | Recovery mode status |

## Verification
The registered results appear one clock after their cause. Selection outputs and `recovery_o` change on the edge that samples a write or an expiry, and `sys_rst_o` rises on that same edge. The bench drives inputs on falling edges and reads outputs on the next falling edge. With ticks on every cycle, it counts `timeout` rising edges after the edge that samples the enable write, and expects `recovery_o` low after `timeout`−1 of them and high after the last. The reset pulse length is measured by counting falling edges with `sys_rst_o` high, which must total 8. The sparse-tick case instead counts tick pulses and ignores clock cycles.

// File: rtl/wfr_pkg.sv
package wfr_pkg;
  localparam int CODE_W = 5;
  localparam int N_W    = 8;
  localparam int M_W    = 7;

  typedef struct packed {
    logic              nm;
    logic [N_W-1:0]    n;
    logic [M_W-1:0]    m;
    logic [CODE_W-1:0] code;
  } fsel_t;

  // expiry test: the tick that brings the count to the timeout
  function automatic logic wd_hit(input logic [31:0] cnt, input logic [31:0] tmo);
    return (cnt + 32'd1) >= tmo;
  endfunction

  function automatic fsel_t code_sel(input logic [CODE_W-1:0] c);
    fsel_t s;
    s = '0;
    s.code = c;
    return s;
  endfunction

  function automatic fsel_t nm_sel(input logic [CODE_W-1:0] c,
                                   input logic [N_W-1:0] n, input logic [M_W-1:0] m);
    fsel_t s;
    s.nm = 1'b1;
    s.n = n;
    s.m = m;
    s.code = c;
    return s;
  endfunction
endpackage

// File: rtl/wfr_counter.sv
module wfr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             hold,
  input  logic             restart,
  input  logic [CNT_W-1:0] tmo,
  output logic             expire
);
  import wfr_pkg::*;
  logic [CNT_W-1:0] cnt;
  logic             armed;

  assign armed  = en && !hold && !restart;
  assign expire = armed && tick && wd_hit(32'(cnt), 32'(tmo));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!armed)     cnt <= '0;
    else if (expire)     cnt <= '0;
    else if (tick)       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wfr_rst_pulse.sv
module wfr_rst_pulse #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic trig,
  output logic pulse
);
  localparam int LW = $clog2(LEN + 1);
  logic [LW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   left <= '0;
    else if (trig)                left <= LW'(LEN);
    else if (tick && left != '0)  left <= left - 1'b1;
  end

  assign pulse = (left != '0);
endmodule

// File: rtl/wfr_freq_sel.sv
module wfr_freq_sel
  import wfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] strap_i,
  input  logic [CODE_W-1:0] sw_code_i,
  input  logic              ovr_i,
  input  logic              freq_wr_i,
  input  logic              rcv_src_i,
  input  logic [N_W-1:0]    rcv_n_i,
  input  logic [M_W-1:0]    rcv_m_i,
  input  logic              expire_i,
  input  logic              wd_en_i,
  output fsel_t             sel_o,
  output logic              rcv_o,
  output logic              chg_o
);
  logic              strap_vld;
  logic [CODE_W-1:0] strap_q;
  fsel_t             cur, wr_sel, rcv_sel;
  logic              wr_ok;

  assign wr_sel  = code_sel(ovr_i ? sw_code_i : strap_q);
  assign rcv_sel = rcv_src_i ? nm_sel(strap_q, rcv_n_i, rcv_m_i) : code_sel(strap_q);
  assign wr_ok   = freq_wr_i && strap_vld && !rcv_o && !expire_i;
  assign chg_o   = wr_ok && (wr_sel != cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_vld <= 1'b0;
      strap_q   <= '0;
    end else if (!strap_vld) begin
      strap_vld <= 1'b1;
      strap_q   <= strap_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cur <= '0;
    else if (!strap_vld) cur <= code_sel(strap_i);
    else if (expire_i)   cur <= rcv_sel;
    else if (wr_ok)      cur <= wr_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rcv_o <= 1'b0;
    else if (!wd_en_i) rcv_o <= 1'b0;
    else if (expire_i) rcv_o <= 1'b1;
  end

  assign sel_o = cur;
endmodule

// File: rtl/wdt_freq_recovery.sv
module wdt_freq_recovery #(
  parameter int CNT_W      = 16,
  parameter int RST_LEN    = 8,
  parameter bit RST_ON_CHG = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_i,
  input  logic                      wd_en_i,
  input  logic                      en_wr_i,
  input  logic                      kick_i,
  input  logic [CNT_W-1:0]          timeout_i,
  input  logic                      rcv_src_i,
  input  logic [wfr_pkg::N_W-1:0]   rcv_n_i,
  input  logic [wfr_pkg::M_W-1:0]   rcv_m_i,
  input  logic [wfr_pkg::CODE_W-1:0] sw_code_i,
  input  logic                      ovr_i,
  input  logic [wfr_pkg::CODE_W-1:0] strap_i,
  input  logic                      freq_wr_i,
  output logic [wfr_pkg::CODE_W-1:0] freq_code_o,
  output logic                      use_nm_o,
  output logic [wfr_pkg::N_W-1:0]   n_o,
  output logic [wfr_pkg::M_W-1:0]   m_o,
  output logic                      sys_rst_o,
  output logic                      recovery_o
);
  import wfr_pkg::*;

  logic  expire_evt;
  logic  chg_evt;
  logic  rst_trig;
  fsel_t sel;

  wfr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .en(wd_en_i),
    .hold(recovery_o), .restart(kick_i || en_wr_i),
    .tmo(timeout_i), .expire(expire_evt)
  );

  wfr_freq_sel u_sel (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .sw_code_i(sw_code_i),
    .ovr_i(ovr_i), .freq_wr_i(freq_wr_i), .rcv_src_i(rcv_src_i),
    .rcv_n_i(rcv_n_i), .rcv_m_i(rcv_m_i), .expire_i(expire_evt),
    .wd_en_i(wd_en_i), .sel_o(sel), .rcv_o(recovery_o), .chg_o(chg_evt)
  );

  assign rst_trig = expire_evt || (RST_ON_CHG && chg_evt);

  wfr_rst_pulse #(.LEN(RST_LEN)) u_rst (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .trig(rst_trig), .pulse(sys_rst_o)
  );

  assign freq_code_o = sel.code;
  assign use_nm_o    = sel.nm;
  assign n_o         = sel.n;
  assign m_o         = sel.m;
endmodule

// File: rtl/wfr_checker.sv
module wfr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       wd_en_i,
  input logic       rcv_src_i,
  input logic [7:0] rcv_n_i,
  input logic [6:0] rcv_m_i,
  input logic [4:0] freq_code_o,
  input logic       use_nm_o,
  input logic [7:0] n_o,
  input logic [6:0] m_o,
  input logic       sys_rst_o,
  input logic       recovery_o,
  input logic       expire_evt,
  input logic       rst_trig
);
  AST_EXPIRE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> sys_rst_o && recovery_o); // R4
  AST_RST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o && !tick_i |=> sys_rst_o); // R3
  AST_NM_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt && rcv_src_i |=> use_nm_o && n_o == $past(rcv_n_i) && m_o == $past(rcv_m_i)); // R6
  AST_LOCKED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_o |=> $stable({freq_code_o, use_nm_o, n_o, m_o})); // R7
  AST_NO_REEXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_o |-> !expire_evt); // R7
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en_i |=> !recovery_o); // R8
  AST_NO_EXPIRE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en_i |-> !expire_evt); // R8
  AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_trig |=> sys_rst_o); // R10
endmodule

bind wdt_freq_recovery wfr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wd_en_i(wd_en_i),
  .rcv_src_i(rcv_src_i), .rcv_n_i(rcv_n_i), .rcv_m_i(rcv_m_i),
  .freq_code_o(freq_code_o), .use_nm_o(use_nm_o), .n_o(n_o), .m_o(m_o),
  .sys_rst_o(sys_rst_o), .recovery_o(recovery_o),
  .expire_evt(expire_evt), .rst_trig(rst_trig)
);

// File: tb/wdt_freq_recovery_tb.sv
module wdt_freq_recovery_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b1;
  logic        wd_en_i = 1'b0, en_wr_i = 1'b0, kick_i = 1'b0;
  logic [15:0] timeout_i = 16'd10;
  logic        rcv_src_i = 1'b0;
  logic [7:0]  rcv_n_i = 8'h00;
  logic [6:0]  rcv_m_i = 7'h00;
  logic [4:0]  sw_code_i = 5'h00;
  logic        ovr_i = 1'b0;
  logic [4:0]  strap_i = 5'h0A;
  logic        freq_wr_i = 1'b0;
  logic [4:0]  freq_code_o;
  logic        use_nm_o;
  logic [7:0]  n_o;
  logic [6:0]  m_o;
  logic        sys_rst_o, recovery_o;

  int n_chk = 0;
  int n_fail = 0;
  localparam logic [4:0] STRAP = 5'h0A;

  always #10 clk = ~clk;

  wdt_freq_recovery u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wd_en_i(wd_en_i),
    .en_wr_i(en_wr_i), .kick_i(kick_i), .timeout_i(timeout_i),
    .rcv_src_i(rcv_src_i), .rcv_n_i(rcv_n_i), .rcv_m_i(rcv_m_i),
    .sw_code_i(sw_code_i), .ovr_i(ovr_i), .strap_i(strap_i),
    .freq_wr_i(freq_wr_i), .freq_code_o(freq_code_o), .use_nm_o(use_nm_o),
    .n_o(n_o), .m_o(m_o), .sys_rst_o(sys_rst_o), .recovery_o(recovery_o)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fwrite(input logic ovr, input logic [4:0] code);
    ovr_i = ovr; sw_code_i = code; freq_wr_i = 1'b1;
    @(negedge clk);
    freq_wr_i = 1'b0;
  endtask

  task automatic arm(input logic [15:0] t);
    timeout_i = t; wd_en_i = 1'b1; en_wr_i = 1'b1;
    @(negedge clk);
    en_wr_i = 1'b0;
  endtask

  task automatic disarm();
    wd_en_i = 1'b0; en_wr_i = 1'b1;
    @(negedge clk);
    en_wr_i = 1'b0;
  endtask

  // counts cycles with the reset pulse high, starting at the current negedge
  task automatic pulse_len(output int len);
    len = 0;
    for (int i = 0; i < 40; i++) begin
      if (sys_rst_o) len++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    idle(2);
    chk(freq_code_o == STRAP, "R11 code", freq_code_o, STRAP);
    chk(!use_nm_o && !sys_rst_o && !recovery_o, "R11 flags",
        {use_nm_o, sys_rst_o, recovery_o}, 0);
  endtask

  task automatic t_strap_once();
    strap_i = 5'h15;
    idle(2);
    fwrite(1'b0, 5'h1F);
    chk(freq_code_o == STRAP, "R12 strap kept", freq_code_o, STRAP);
    chk(!sys_rst_o, "R10 same selection no pulse", sys_rst_o, 0);
  endtask

  task automatic t_sw_write();
    int len;
    fwrite(1'b1, 5'h13);
    chk(freq_code_o == 5'h13 && !use_nm_o, "R9 override code", freq_code_o, 5'h13);
    pulse_len(len);
    chk(len == 8, "R10 change pulse length", len, 8);
    fwrite(1'b0, 5'h13);
    chk(freq_code_o == STRAP, "R9 strap code", freq_code_o, STRAP);
    idle(12);
  endtask

  task automatic t_timeout_strap();
    int len;
    fwrite(1'b1, 5'h07);
    idle(12);
    rcv_src_i = 1'b0;
    arm(16'd10);
    idle(9);
    chk(!recovery_o, "R1 no early expiry", recovery_o, 0);
    idle(1);
    chk(recovery_o, "R1 expiry on time", recovery_o, 1);
    chk(freq_code_o == STRAP && !use_nm_o, "R5 strap recovery", freq_code_o, STRAP);
    pulse_len(len);
    chk(len == 8, "R4 expiry pulse length", len, 8);
    fwrite(1'b1, 5'h1F);
    chk(freq_code_o == STRAP, "R7 write locked", freq_code_o, STRAP);
    pulse_len(len);
    chk(len == 0 && recovery_o, "R7 no reset and still recovering", len, 0);
    disarm();
    chk(!recovery_o, "R8 released", recovery_o, 1'b0);
    fwrite(1'b1, 5'h1F);
    chk(freq_code_o == 5'h1F, "R8 writes work again", freq_code_o, 5'h1F);
    idle(12);
  endtask

  task automatic t_kick();
    arm(16'd10);
    for (int k = 0; k < 4; k++) begin
      idle(6);
      kick_i = 1'b1; @(negedge clk); kick_i = 1'b0;
    end
    chk(!recovery_o && !sys_rst_o, "R2 kicks prevent expiry", recovery_o, 0);
    idle(9);
    chk(!recovery_o, "R2 restart from kick", recovery_o, 0);
    idle(1);
    chk(recovery_o, "R2 expiry after kicks stop", recovery_o, 1);
    disarm();
    idle(12);
  endtask

  task automatic t_nm();
    rcv_src_i = 1'b1; rcv_n_i = 8'hA5; rcv_m_i = 7'h5A;
    arm(16'd5);
    idle(5);
    chk(recovery_o && use_nm_o, "R6 nm selected", use_nm_o, 1);
    chk(n_o == 8'hA5 && m_o == 7'h5A, "R6 nm values", {n_o, 1'b0, m_o}, {8'hA5, 1'b0, 7'h5A});
    disarm();
    rcv_src_i = 1'b0;
    idle(12);
  endtask

  task automatic t_disabled();
    timeout_i = 16'd3;
    wd_en_i = 1'b0;
    idle(30);
    chk(!recovery_o && !sys_rst_o, "R8 no expiry while disabled", recovery_o, 0);
  endtask

  task automatic t_sparse_tick();
    tick_i = 1'b0;
    arm(16'd3);
    idle(20);
    chk(!recovery_o, "R3 no count without ticks", recovery_o, 0);
    for (int k = 0; k < 2; k++) begin
      tick_i = 1'b1; @(negedge clk); tick_i = 1'b0; idle(3);
    end
    chk(!recovery_o, "R3 two ticks not enough", recovery_o, 0);
    tick_i = 1'b1; @(negedge clk); tick_i = 1'b0;
    chk(recovery_o, "R3 third tick expires", recovery_o, 1);
    idle(10);
    chk(sys_rst_o, "R4 pulse waits for ticks", sys_rst_o, 1);
    disarm();
    tick_i = 1'b1;
    idle(12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_strap_once();
    t_sw_write();
    t_timeout_strap();
    t_kick();
    t_nm();
    t_disabled();
    t_sparse_tick();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule